// File: doc/BRIEF.md
# Split-Transaction Request Limiter

This block sits between two read requesters, one for transmit traffic and one for receive traffic, and a bus that allows only a bounded number of split transactions to be outstanding. Each requester raises its request line. The block answers in the same cycle with a grant when the request may go out. The bus side pulses a completion strobe each time a split transaction finishes. The block keeps the number of outstanding transactions, never lets it pass the programmed ceiling, and presents it on an output.

Two limits apply. A 3-bit code selects the overall ceiling. A separate shared-split value stops transmit requests at a lower level, which keeps the remaining slots free for receive. A shared-split value of zero removes the separate transmit limit. Internally, a small state machine classifies the outstanding count into four states:
- `ST_EMPTY`: nothing outstanding.
- `ST_OPEN`: both requesters may issue.
- `ST_TX_HOLD`: only receive may issue.
- `ST_FULL`: nobody may issue.

The named transitions are:
- `ST_EMPTY`→`ST_OPEN` on the first issue.
- `ST_OPEN`→`ST_TX_HOLD` when the transmit limit is reached.
- `ST_TX_HOLD`→`ST_FULL` when the overall ceiling is reached.
- `ST_FULL`→`ST_TX_HOLD` or `ST_OPEN` on completions.
- Any non-empty state→`ST_EMPTY` on the last completion.
- Direct jumps between any pair of states when the limits coincide (for example, with a ceiling of 1, `ST_EMPTY`→`ST_FULL`).

Top module: `split_req_limiter`

## Requirements
- R1: After reset, `outstanding` is 0 and `cpl_err` is 0, and with no requests raised no grant is given.
- R2: The overall ceiling follows `max_code`: 0→1, 1→2, 2→3, 3→4, 4→8, 5→12, 6→16, 7→32. A receive request is granted exactly while `outstanding` is below the ceiling.
- R3: With `shared_lim` from 1 to 31, a transmit request is granted only while `outstanding` is below the smaller of `shared_lim` and the overall ceiling.
- R4: With `shared_lim` equal to 0, transmit requests are granted up to the overall ceiling, just like receive requests.
- R5: Receive requests keep being granted after the transmit limit has been reached, until the overall ceiling.
- R6: At most one grant is given per cycle. When both requesters ask and both are eligible, receive is granted and transmit is not.
- R7: A grant without a valid completion raises `outstanding` by 1 at the next clock edge. A valid completion without a grant lowers it by 1.
- R8: A grant and a valid completion in the same cycle leave `outstanding` unchanged.
- R9: A completion while `outstanding` is 0 does not change the count. In that case `cpl_err` is 1 for exactly the following cycle; otherwise `cpl_err` is 0.
- R10: No grant is given to a requester whose request line is low.
- R11: A change of `max_code` or `shared_lim` governs the grants from the cycle after the next clock edge. If the ceiling is lowered below the count, all grants stop until completions bring the count under it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_req | input | 1 | Transmit requester wants to issue a read |
| rx_req | input | 1 | Receive requester wants to issue a read |
| cpl | input | 1 | One split transaction completed this cycle |
| max_code | input | 3 | Encoded overall ceiling |
| shared_lim | input | SHARE_W (5) | Transmit limit, 0 disables it |
| tx_gnt | output | 1 | Transmit request issued this cycle |
| rx_gnt | output | 1 | Receive request issued this cycle |
| outstanding | output | CNT_W (6) | Split transactions currently outstanding |
| cpl_err | output | 1 | Previous cycle had a completion with nothing outstanding |

## Verification
The bench builds the block with its defaults: a 6-bit count and a 5-bit shared value. With these, all eight ceiling codes can be driven to their limit, including the 32-deep one where the counter's top bit is used. Because the shared value can be set above every ceiling but the largest, the case where the overall ceiling rather than the shared value stops transmit is also reached. Lowering either limit while transactions are in flight exercises the path where the count already sits above the new ceiling.

// File: rtl/split_lim_pkg.sv
package split_lim_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [1:0] {
        ST_EMPTY,
        ST_OPEN,
        ST_TX_HOLD,
        ST_FULL
    } lim_state_e;

    // Overall ceiling selected by the 3-bit code.
    function automatic int unsigned max_of(input logic [CODE_W-1:0] code);
        int unsigned v;
        unique case (code)
            3'd0:    v = 1;
            3'd1:    v = 2;
            3'd2:    v = 3;
            3'd3:    v = 4;
            3'd4:    v = 8;
            3'd5:    v = 12;
            3'd6:    v = 16;
            default: v = 32;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/split_lim_thresh.sv
module split_lim_thresh
    import split_lim_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int SHARE_W = 5
) (
    input  logic [CODE_W-1:0]  max_code,
    input  logic [SHARE_W-1:0] shared_lim,
    output logic [CNT_W-1:0]   max_lim,
    output logic [CNT_W-1:0]   tx_lim
);

    logic [CNT_W-1:0] share_ext;

    always_comb begin
        max_lim   = CNT_W'(max_of(max_code));
        share_ext = CNT_W'(shared_lim);
        if (shared_lim == '0 || share_ext > max_lim) begin
            tx_lim = max_lim;
        end else begin
            tx_lim = share_ext;
        end
    end

endmodule

// File: rtl/split_lim_counter.sv
module split_lim_counter #(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             cpl,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_d,
    output logic             err_q
);

    logic dec;
    logic stray;

    assign stray = cpl && (cnt_q == '0);
    assign dec   = cpl && (cnt_q != '0);

    always_comb begin
        cnt_d = cnt_q;
        if (inc && !dec) begin
            cnt_d = cnt_q + CNT_W'(1);
        end else if (!inc && dec) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            err_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            err_q <= stray;
        end
    end

endmodule

// File: rtl/split_lim_fsm.sv
module split_lim_fsm
    import split_lim_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_req,
    input  logic             rx_req,
    input  logic [CNT_W-1:0] cnt_d,
    input  logic [CNT_W-1:0] max_lim,
    input  logic [CNT_W-1:0] tx_lim,
    output logic             tx_gnt,
    output logic             rx_gnt
);

    lim_state_e state_q;
    lim_state_e state_d;

    // Classify the count the counter will hold after this edge.
    always_comb begin
        if (cnt_d >= max_lim) begin
            state_d = ST_FULL;
        end else if (cnt_d >= tx_lim) begin
            state_d = ST_TX_HOLD;
        end else if (cnt_d == '0) begin
            state_d = ST_EMPTY;
        end else begin
            state_d = ST_OPEN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (state_q)
            ST_EMPTY, ST_OPEN: begin
                rx_gnt = rx_req;
                tx_gnt = tx_req && !rx_req;
            end
            ST_TX_HOLD: begin
                rx_gnt = rx_req;
                tx_gnt = 1'b0;
            end
            ST_FULL: begin
                rx_gnt = 1'b0;
                tx_gnt = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/split_req_limiter.sv
module split_req_limiter
    import split_lim_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int SHARE_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tx_req,
    input  logic               rx_req,
    input  logic               cpl,
    input  logic [2:0]         max_code,
    input  logic [SHARE_W-1:0] shared_lim,
    output logic               tx_gnt,
    output logic               rx_gnt,
    output logic [CNT_W-1:0]   outstanding,
    output logic               cpl_err
);

    logic [CNT_W-1:0] max_lim;
    logic [CNT_W-1:0] tx_lim;
    logic [CNT_W-1:0] cnt_d;
    logic             issue;

    assign issue = tx_gnt || rx_gnt;

    split_lim_thresh #(.CNT_W(CNT_W), .SHARE_W(SHARE_W)) u_thresh (
        .max_code   (max_code),
        .shared_lim (shared_lim),
        .max_lim    (max_lim),
        .tx_lim     (tx_lim)
    );

    split_lim_counter #(.CNT_W(CNT_W)) u_count (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (issue),
        .cpl   (cpl),
        .cnt_q (outstanding),
        .cnt_d (cnt_d),
        .err_q (cpl_err)
    );

    split_lim_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .tx_req  (tx_req),
        .rx_req  (rx_req),
        .cnt_d   (cnt_d),
        .max_lim (max_lim),
        .tx_lim  (tx_lim),
        .tx_gnt  (tx_gnt),
        .rx_gnt  (rx_gnt)
    );

endmodule

// File: rtl/split_lim_chk.sv
module split_lim_chk
    import split_lim_pkg::*;
#(
    parameter int CNT_W   = 6,
    parameter int SHARE_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_req,
    input logic               rx_req,
    input logic               cpl,
    input logic [2:0]         max_code,
    input logic [SHARE_W-1:0] shared_lim,
    input logic               tx_gnt,
    input logic               rx_gnt,
    input logic [CNT_W-1:0]   outstanding,
    input logic               cpl_err
);

    a_r6_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_gnt && rx_gnt));

    a_r10_rx_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        rx_gnt |-> rx_req);

    a_r10_tx_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_gnt |-> tx_req);

    a_r7_count_up: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_gnt || rx_gnt) && !cpl) |=> outstanding == $past(outstanding) + CNT_W'(1));

    a_r7_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!(tx_gnt || rx_gnt) && cpl && outstanding != '0)
            |=> outstanding == $past(outstanding) - CNT_W'(1));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_gnt || rx_gnt) && cpl && outstanding != '0) |=> $stable(outstanding));

    a_r9_stray_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl && outstanding == '0) |=> cpl_err);

    a_r9_no_false_flag: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpl && outstanding == '0) |=> !cpl_err);

    a_r2_rx_ceiling: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_gnt && $stable(max_code)) |-> 32'(outstanding) < max_of(max_code));

    a_r3_tx_shared: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_gnt && $stable(max_code) && $stable(shared_lim) && shared_lim != '0)
            |-> outstanding < CNT_W'(shared_lim));

endmodule

bind split_req_limiter split_lim_chk #(.CNT_W(CNT_W), .SHARE_W(SHARE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_req      (tx_req),
    .rx_req      (rx_req),
    .cpl         (cpl),
    .max_code    (max_code),
    .shared_lim  (shared_lim),
    .tx_gnt      (tx_gnt),
    .rx_gnt      (rx_gnt),
    .outstanding (outstanding),
    .cpl_err     (cpl_err)
);

// File: tb/test_split_req_limiter.sv
module test_split_req_limiter;

    localparam int CLK_P   = 10;
    localparam int CNT_W   = 6;
    localparam int SHARE_W = 5;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               tx_req = 1'b0;
    logic               rx_req = 1'b0;
    logic               cpl = 1'b0;
    logic [2:0]         max_code = 3'd7;
    logic [SHARE_W-1:0] shared_lim = '0;
    logic               tx_gnt;
    logic               rx_gnt;
    logic [CNT_W-1:0]   outstanding;
    logic               cpl_err;

    int n_chk  = 0;
    int n_fail = 0;
    int m      = 0;   // bench view of the outstanding count

    always #(CLK_P/2) clk = ~clk;

    split_req_limiter #(.CNT_W(CNT_W), .SHARE_W(SHARE_W)) i_split_req_limiter (
        .clk         (clk),
        .rst_n       (rst_n),
        .tx_req      (tx_req),
        .rx_req      (rx_req),
        .cpl         (cpl),
        .max_code    (max_code),
        .shared_lim  (shared_lim),
        .tx_gnt      (tx_gnt),
        .rx_gnt      (rx_gnt),
        .outstanding (outstanding),
        .cpl_err     (cpl_err)
    );

    function automatic int ceil_of(input int c);
        case (c)
            0: return 1;
            1: return 2;
            2: return 3;
            3: return 4;
            4: return 8;
            5: return 12;
            6: return 16;
            default: return 32;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // One cycle: drive at negedge, check grants, then count and flag after the edge.
    task automatic step(input logic t, input logic r, input logic c, input string tag);
        int  cap;
        int  txl;
        bit  e_rx;
        bit  e_tx;
        bit  e_err;
        @(negedge clk);
        tx_req = t;
        rx_req = r;
        cpl    = c;
        cap = ceil_of(int'(max_code));
        txl = (shared_lim == 0 || int'(shared_lim) > cap) ? cap : int'(shared_lim);
        e_rx = r && (m < cap);
        e_tx = t && (m < txl) && !e_rx;
        #1;
        chk(rx_gnt == e_rx, tag, "rx_gnt", int'(rx_gnt), int'(e_rx));
        chk(tx_gnt == e_tx, tag, "tx_gnt", int'(tx_gnt), int'(e_tx));
        e_err = c && (m == 0);
        m = m + ((e_rx || e_tx) ? 1 : 0) - ((c && m != 0) ? 1 : 0);
        @(posedge clk);
        #1;
        chk(int'(outstanding) == m, tag, "outstanding", int'(outstanding), m);
        chk(cpl_err == e_err, tag, "cpl_err", int'(cpl_err), int'(e_err));
        tx_req = 1'b0;
        rx_req = 1'b0;
        cpl    = 1'b0;
    endtask

    task automatic set_cfg(input logic [2:0] code, input logic [SHARE_W-1:0] sh);
        @(negedge clk);
        max_code   = code;
        shared_lim = sh;
        step(1'b0, 1'b0, 1'b0, "R11");
    endtask

    task automatic drain(input string tag);
        while (m > 0) step(1'b0, 1'b0, 1'b1, tag);
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(outstanding == '0, "R1", "outstanding in reset", int'(outstanding), 0);
        chk(cpl_err == 1'b0, "R1", "cpl_err in reset", int'(cpl_err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        m = 0;
        step(1'b0, 1'b0, 1'b0, "R1");
    endtask

    task automatic t_decode;
        for (int c = 0; c < 8; c++) begin
            set_cfg(3'(c), '0);
            for (int k = 0; k <= ceil_of(c); k++) step(1'b0, 1'b1, 1'b0, "R2");
            drain("R7");
        end
    endtask

    task automatic t_shared;
        set_cfg(3'd6, 5'd5);
        for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0, "R3");
        for (int k = 0; k < 12; k++) step(1'b0, 1'b1, 1'b0, "R5");
        step(1'b1, 1'b1, 1'b0, "R5");
        drain("R7");
        set_cfg(3'd4, 5'd20);
        for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 1'b0, "R3");
        drain("R7");
    endtask

    task automatic t_shared_zero;
        set_cfg(3'd5, '0);
        for (int k = 0; k < 14; k++) step(1'b1, 1'b0, 1'b0, "R4");
        drain("R7");
    endtask

    task automatic t_both;
        set_cfg(3'd3, 5'd2);
        step(1'b1, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b0, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R6");
        step(1'b1, 1'b1, 1'b0, "R6");
        step(1'b0, 1'b0, 1'b0, "R10");
        drain("R7");
    endtask

    task automatic t_overlap;
        set_cfg(3'd4, '0);
        step(1'b0, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b0, "R7");
        step(1'b0, 1'b1, 1'b1, "R8");
        step(1'b1, 1'b0, 1'b1, "R8");
        step(1'b0, 1'b0, 1'b1, "R7");
        drain("R7");
    endtask

    task automatic t_stray;
        set_cfg(3'd4, '0);
        step(1'b0, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b0, 1'b1, "R9");
        step(1'b0, 1'b0, 1'b0, "R9");
    endtask

    task automatic t_reconfig;
        set_cfg(3'd6, 5'd8);
        for (int k = 0; k < 4; k++) step(1'b1, 1'b0, 1'b0, "R11");
        set_cfg(3'd6, 5'd3);
        step(1'b1, 1'b0, 1'b0, "R11");
        step(1'b1, 1'b1, 1'b0, "R11");
        set_cfg(3'd1, 5'd3);
        step(1'b1, 1'b1, 1'b0, "R11");
        step(1'b0, 1'b0, 1'b1, "R11");
        step(1'b0, 1'b0, 1'b1, "R11");
        step(1'b0, 1'b0, 1'b1, "R11");
        step(1'b0, 1'b1, 1'b0, "R11");
        drain("R7");
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_decode();
        t_shared();
        t_shared_zero();
        t_both();
        t_overlap();
        t_stray();
        t_reconfig();
        finish_run();
    end

endmodule